// File: doc/BRIEF.md
# Shutter Auto-Exposure Controller

This block closes a per-frame exposure loop around an image sensor. It holds a 16-bit shutter duration counted in system clock cycles. At the end of each frame it receives statistics: the brightest pixel and the mean pixel level, both on a 6-bit scale. It then lengthens or shortens the shutter by one sixteenth of its present value, so that the brightest pixel settles in the mid-50s. The result is always kept between one clock and a ceiling. That ceiling is the clock-cycle budget of one frame, less a fixed readout overhead.

At each frame start the block raises an illumination enable and holds it for exactly the programmed number of clocks. The shutter can be read as two bytes. A read of the upper byte captures the lower byte at the same instant. The following read of the lower byte therefore returns a value consistent with the upper byte, even if the loop has moved the shutter between the two reads. Frame timing and image sensing live outside the block: frame start and frame end arrive as single-cycle pulses.

Top module: `shutter_ae_ctrl`

## Requirements
- R1: After reset the shutter is 0x0100, a read of the upper byte returns 0x01, a read of the lower byte returns 0x00, and the illumination enable is low.
- R2: At a frame end whose maximum pixel is below 52, the shutter grows by max(shutter/16, 1), where shutter/16 is the value shifted right by four.
- R3: At a frame end whose maximum pixel is above 57, the shutter shrinks by max(shutter/16, 1).
- R4: At a frame end whose maximum pixel lies between 52 and 57 inclusive, the shutter keeps its value.
- R5: The shutter never exceeds the ceiling CLK_HZ/FRAME_HZ - OVERHEAD; an increase that would pass it lands on the ceiling.
- R6: The shutter never drops below 1; a decrease that would reach 0 lands on 1.
- R7: The shutter changes at most once per frame end and on no other cycle; a frame end whose mean pixel exceeds its maximum pixel is discarded and leaves the shutter unchanged.
- R8: The illumination enable rises on the cycle after a frame start pulse and stays high for exactly the shutter value in clock cycles.
- R9: A read strobe with select 0 returns the upper shutter byte, and with select 1 the lower byte, on the read data output one cycle after the strobe.
- R10: The lower-byte read returns the lower byte as it was at the most recent upper-byte read, even if the shutter has changed since.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse at the start of a frame |
| frame_end | input | 1 | One-cycle pulse marking valid statistics |
| max_pix | input | 6 | Brightest pixel of the finished frame |
| avg_pix | input | 6 | Mean pixel level of the finished frame |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 1 | Byte select: 0 upper, 1 lower |
| rd_data | output | 8 | Read data, valid the cycle after the strobe |
| illum_en | output | 1 | Illumination / exposure enable |

## Verification
The bench builds the block with a 600 kHz clock, 100 frames per second and an overhead of 3476, so the ceiling is 2524. Both bounds can then be reached within a few hundred frame-end pulses, and a full illumination window can be counted clock by clock. With these values the one-clock step near the floor, the clamp at the ceiling and the torn-read case all come up in a short run.

// File: rtl/ae_pkg.sv
package ae_pkg;
  typedef enum logic {
    SEL_UPPER = 1'b0,
    SEL_LOWER = 1'b1
  } byte_sel_e;

  typedef enum logic [1:0] {
    ADJ_HOLD = 2'd0,
    ADJ_UP   = 2'd1,
    ADJ_DOWN = 2'd2
  } adj_dir_e;
endpackage

// File: rtl/ae_step_calc.sv
module ae_step_calc
  import ae_pkg::*;
#(
  parameter int SHUT_W     = 16,
  parameter int PIX_W      = 6,
  parameter int STEP_SHIFT = 4,
  parameter int LO_THR     = 52,
  parameter int HI_THR     = 57,
  parameter logic [SHUT_W-1:0] SHUT_MAX = 16'd12524
) (
  input  logic [SHUT_W-1:0] cur_shut,
  input  logic [PIX_W-1:0]  max_pix,
  input  logic [PIX_W-1:0]  avg_pix,
  output logic [SHUT_W-1:0] nxt_shut
);
  localparam logic [SHUT_W-1:0] ONE = SHUT_W'(1);

  adj_dir_e          dir;
  logic [SHUT_W-1:0] step;
  logic [SHUT_W:0]   sum;

  always_comb begin
    step = cur_shut >> STEP_SHIFT;
    if (step == '0) step = ONE;
  end

  always_comb begin
    if (avg_pix > max_pix)             dir = ADJ_HOLD;
    else if (max_pix < PIX_W'(LO_THR)) dir = ADJ_UP;
    else if (max_pix > PIX_W'(HI_THR)) dir = ADJ_DOWN;
    else                               dir = ADJ_HOLD;
  end

  always_comb begin
    sum = {1'b0, cur_shut} + {1'b0, step};
    unique case (dir)
      ADJ_UP:   nxt_shut = (sum > {1'b0, SHUT_MAX}) ? SHUT_MAX : sum[SHUT_W-1:0];
      ADJ_DOWN: nxt_shut = (cur_shut <= step) ? ONE : (cur_shut - step);
      default:  nxt_shut = cur_shut;
    endcase
  end
endmodule

// File: rtl/ae_illum_timer.sv
module ae_illum_timer #(
  parameter int SHUT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [SHUT_W-1:0] load_val,
  output logic              illum_en
);
  logic [SHUT_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  always_comb begin
    cnt_en = frame_start || (cnt_q != '0);
    cnt_d  = frame_start ? load_val : (cnt_q - SHUT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign illum_en = (cnt_q != '0);

  AST_ILLUM_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && load_val != '0) |=> illum_en); // R8
  AST_ILLUM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && !illum_en) |=> !illum_en); // R8
endmodule

// File: rtl/ae_byte_read.sv
module ae_byte_read
  import ae_pkg::*;
#(
  parameter int SHUT_W = 16,
  parameter logic [SHUT_W-1:0] SHUT_RST = 16'h0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              rd_sel,
  input  logic [SHUT_W-1:0] shut,
  output logic [SHUT_W/2-1:0] rd_data
);
  localparam int BYTE_W = SHUT_W / 2;

  byte_sel_e         sel;
  logic [BYTE_W-1:0] hold_q, hold_d, data_q, data_d;
  logic              hold_en;

  always_comb begin
    sel     = byte_sel_e'(rd_sel);
    hold_en = rd_en && (sel == SEL_UPPER);
    hold_d  = shut[BYTE_W-1:0];
    data_d  = (sel == SEL_UPPER) ? shut[SHUT_W-1:BYTE_W] : hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= SHUT_RST[BYTE_W-1:0];
    else if (hold_en) hold_q <= hold_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     data_q <= '0;
    else if (rd_en) data_q <= data_d;
  end

  assign rd_data = data_q;

  AST_UPPER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_sel) |=> rd_data == $past(shut[SHUT_W-1:BYTE_W])); // R9
  AST_LOWER_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_sel) |=> hold_q == $past(shut[BYTE_W-1:0])); // R10
endmodule

// File: rtl/shutter_ae_ctrl.sv
module shutter_ae_ctrl #(
  parameter int CLK_HZ     = 24000000,
  parameter int FRAME_HZ   = 1500,
  parameter int OVERHEAD   = 3476,
  parameter int SHUT_W     = 16,
  parameter int PIX_W      = 6,
  parameter int STEP_SHIFT = 4,
  parameter int LO_THR     = 52,
  parameter int HI_THR     = 57,
  parameter logic [SHUT_W-1:0] SHUT_RST = 16'h0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              frame_end,
  input  logic [PIX_W-1:0]  max_pix,
  input  logic [PIX_W-1:0]  avg_pix,
  input  logic              rd_en,
  input  logic              rd_sel,
  output logic [SHUT_W/2-1:0] rd_data,
  output logic              illum_en
);
  localparam int MAX_INT = CLK_HZ / FRAME_HZ - OVERHEAD;
  localparam logic [SHUT_W-1:0] SHUT_MAX = SHUT_W'(MAX_INT);

  logic [SHUT_W-1:0] shut_q, shut_calc;

  ae_step_calc #(
    .SHUT_W(SHUT_W), .PIX_W(PIX_W), .STEP_SHIFT(STEP_SHIFT),
    .LO_THR(LO_THR), .HI_THR(HI_THR), .SHUT_MAX(SHUT_MAX)
  ) i_step (
    .cur_shut(shut_q), .max_pix(max_pix), .avg_pix(avg_pix), .nxt_shut(shut_calc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         shut_q <= SHUT_RST;
    else if (frame_end) shut_q <= shut_calc;
  end

  ae_illum_timer #(.SHUT_W(SHUT_W)) i_timer (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .load_val(shut_q), .illum_en(illum_en)
  );

  ae_byte_read #(.SHUT_W(SHUT_W), .SHUT_RST(SHUT_RST)) i_read (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_sel(rd_sel),
    .shut(shut_q), .rd_data(rd_data)
  );

  AST_SHUT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (shut_q >= SHUT_W'(1)) && (shut_q <= SHUT_MAX)); // R5 R6
  AST_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(shut_q)); // R7
  AST_WINDOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && max_pix >= PIX_W'(LO_THR) && max_pix <= PIX_W'(HI_THR)) |=> $stable(shut_q)); // R4
  AST_BAD_STATS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && avg_pix > max_pix) |=> $stable(shut_q)); // R7
endmodule

// File: tb/test_shutter_ae_ctrl.sv
module test_shutter_ae_ctrl;
  localparam int CLK_HZ = 600000, FRAME_HZ = 100, OVERHEAD = 3476;
  localparam int SMAX = CLK_HZ / FRAME_HZ - OVERHEAD;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_start = 1'b0, frame_end = 1'b0, rd_en = 1'b0, rd_sel = 1'b0;
  logic [5:0] max_pix = '0, avg_pix = '0;
  logic [7:0] rd_data;
  logic       illum_en;

  int tests = 0, fails = 0;
  int exp_shut = 256;

  always #2 clk = ~clk;

  shutter_ae_ctrl #(.CLK_HZ(CLK_HZ), .FRAME_HZ(FRAME_HZ), .OVERHEAD(OVERHEAD)) i_shutter_ae_ctrl (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
    .max_pix(max_pix), .avg_pix(avg_pix), .rd_en(rd_en), .rd_sel(rd_sel),
    .rd_data(rd_data), .illum_en(illum_en)
  );

  function automatic int model_next(int s, int mx, int av);
    int st = s >> 4;
    if (st < 1) st = 1;
    if (av > mx) return s;
    if (mx < 52) return (s + st > SMAX) ? SMAX : s + st;
    if (mx > 57) return (s - st < 1) ? 1 : s - st;
    return s;
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_end(int mx, int av);
    @(negedge clk);
    frame_end = 1'b1; max_pix = 6'(mx); avg_pix = 6'(av);
    @(negedge clk);
    frame_end = 1'b0;
    exp_shut = model_next(exp_shut, mx, av);
  endtask

  task automatic read_byte(logic sel, output int val);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = sel;
    @(negedge clk);
    rd_en = 1'b0;
    val = int'(rd_data);
  endtask

  task automatic read_shut(output int val);
    int hi, lo;
    read_byte(1'b0, hi);
    read_byte(1'b1, lo);
    val = hi * 256 + lo;
  endtask

  task automatic measure_illum(output int n);
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    n = 0;
    while (illum_en && n < 70000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(4 * 190000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int v, hi, lo, old, mx, av;
    void'($urandom(32'd20240917));
    #5;
    check("R1 illum in reset", int'(illum_en), 0);
    @(negedge clk); rst_n = 1'b1;
    read_byte(1'b0, v); check("R1 upper reset", v, 1);
    read_byte(1'b1, v); check("R1 lower reset", v, 0);
    check("R1 illum after reset", int'(illum_en), 0);

    measure_illum(v); check("R8 window at default", v, 256);

    pulse_end(20, 10); read_shut(v); check("R2 increase", v, exp_shut);
    check("R2 value", v, 272);
    pulse_end(63, 30); read_shut(v); check("R3 decrease", v, exp_shut);
    check("R3 value", v, 255);
    pulse_end(52, 40); read_shut(v); check("R4 low edge hold", v, 255);
    pulse_end(57, 40); read_shut(v); check("R4 high edge hold", v, 255);
    pulse_end(10, 11); read_shut(v); check("R7 discarded frame", v, 255);
    repeat (30) @(negedge clk);
    read_shut(v); check("R7 idle no change", v, 255);
    read_byte(1'b1, v); check("R9 lower select", v, 255);

    // R10: snapshot survives a change between reads
    old = exp_shut;
    read_byte(1'b0, hi);
    pulse_end(0, 0);
    read_byte(1'b1, lo);
    check("R10 coherent lower", lo, old % 256);
    check("R10 upper", hi, old / 256);

    for (int i = 0; i < 160; i++) pulse_end(0, 0);
    read_shut(v); check("R5 ceiling", v, SMAX);
    check("R5 model", v, exp_shut);
    measure_illum(v); check("R8 window at ceiling", v, SMAX);

    for (int i = 0; i < 200; i++) pulse_end(63, 0);
    read_shut(v); check("R6 floor", v, 1);
    measure_illum(v); check("R8 window at floor", v, 1);
    pulse_end(2, 1); read_shut(v); check("R2 unit step from 1", v, 2);

    for (int i = 0; i < 300; i++) begin
      mx = int'($urandom_range(63, 0));
      av = (($urandom_range(9, 0)) == 0) ? 63 : int'($urandom_range(mx, 0));
      pulse_end(mx, av);
      if (i % 10 == 9) begin
        read_shut(v); check("R2 R3 R4 R7 random", v, exp_shut);
      end
    end
    measure_illum(v); check("R8 window random", v, exp_shut);

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    exp_shut = 256;
    read_shut(v); check("R1 reset restores", v, 256);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule